// File: doc/BRIEF.md
# Ramp-Compare Conversion Timer

This block turns the time an analog ramp takes to cross an input level into a digital code. A programmable divider slows the system clock into count ticks. A counter starts on a start event and steps once per tick. It stops on the first comparator crossing of the selected direction, and the count it holds at that moment is the conversion result. The comparator itself is analog and sits outside the block. Its output enters here as a single digital line and is resynchronised inside.

There are two ramp sources. With the on-chip capacitor, a start request makes the block enable the charge current and begin counting at once. After every conversion it drives a discharge output for a fixed number of cycles that scales with the divider. With an external ramp generator, a start request arms the block and raises a ready output. The generator then starts its ramp and drives the start input high, and counting begins. Counting can run up from zero or down from all-ones. If the counter reaches its last value and takes one more tick without a crossing, the conversion ends with a wrap flag set. That flag stays set until it is cleared.

Results leave on a valid/ready output. `res_valid` rises together with a one-cycle `eoc_irq` pulse. It stays high, with `res_data` held, until a cycle in which `res_ready` is high. While a result is waiting, start requests are ignored. A slow consumer therefore pauses the converter and never loses a result. Configuration is latched when a start request is accepted.

Top module: `ramp_conv_timer`

## Requirements
- R1: After reset, `res_valid`, `res_data`, `wrap_flag`, `eoc_irq`, `ext_ready`, `cap_charge` and `cap_discharge` are all 0.
- R2: With divider value P, a tick occurs every P+1 clock cycles of counting, so P=0 gives one tick per clock. `cmp_in` passes through two synchroniser flops and an edge detector. If `cmp_in` changes W clock edges after the reference edge (the start-accept edge in capacitor mode, the `ext_start` edge in external mode), the up-count result is floor((W+2)/(P+1)).
- R3: In up mode, a tick that arrives while the count is 0xFFFF ends the conversion with `res_data`=0xFFFF, sets `wrap_flag` and pulses `eoc_irq`.
- R4: `cfg_count_down`=1 starts the count at 0xFFFF and decrements it, so the result is 0xFFFF minus the tick count. A tick at 0 ends the conversion with `res_data`=0 and sets `wrap_flag`.
- R5: In external mode, `cfg_fall_edge`=0 stops the count on a low-to-high comparator change and `cfg_fall_edge`=1 stops it on a high-to-low change. In capacitor mode (`cfg_ext_ramp`=0), only low-to-high counts, whatever `cfg_fall_edge` is.
- R6: In capacitor mode, `cap_charge` is high while counting. After each conversion, `cap_discharge` is high for exactly (P+1)×410 cycles, and the two are never high together.
- R7: In external mode (`cfg_ext_ramp`=1), an accepted start raises `ext_ready`. A high `ext_start` then begins counting and drops `ext_ready` on the next edge. `ext_ready` is low at all other times.
- R8: `res_valid` and `res_data` hold until a cycle with `res_ready` high. While `res_valid` is high, `conv_start` is ignored.
- R9: `wrap_flag` stays set through later conversions until `wrap_clr` is pulsed.
- R10: `eoc_irq` is a one-cycle pulse, issued on the same edge that raises `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prescale | input | 12 | Divider value P; a tick every P+1 cycles |
| cfg_count_down | input | 1 | 1 = count down from 0xFFFF, 0 = up from 0 |
| cfg_fall_edge | input | 1 | External mode: 1 = high-to-low crossing stops the count |
| cfg_ext_ramp | input | 1 | 1 = external ramp with handshake, 0 = on-chip capacitor |
| conv_start | input | 1 | Start request, accepted while idle with no pending result |
| ext_start | input | 1 | External ramp has started; begins counting when armed |
| ext_ready | output | 1 | Armed and waiting for `ext_start` |
| cmp_in | input | 1 | Comparator output, asynchronous |
| cap_charge | output | 1 | Capacitor charge current enable |
| cap_discharge | output | 1 | Capacitor discharge switch |
| res_data | output | 16 | Conversion result |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| eoc_irq | output | 1 | End-of-conversion interrupt pulse |
| wrap_flag | output | 1 | Sticky overflow/underflow status |
| wrap_clr | input | 1 | Clears `wrap_flag` |

## Verification
Some properties are checked on every clock cycle. A held result stays stable under back-pressure. The interrupt lasts one cycle. The wrap flag is sticky, and when it rises the result matches the terminal value of the counting direction. `ext_ready` drops after the start input is taken. Ticks are spaced when P is nonzero. The edge detector never fires twice in a row. Charge and discharge never overlap. Only the bench scenarios can show that the captured count matches the crossing time for each divider and direction. They also show that each edge polarity is honoured in the right mode, that the discharge lasts exactly (P+1)×410 cycles, and that start requests are dropped while a result waits.

// File: rtl/rct_pkg.sv
package rct_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_COUNT = 2'd2,
    ST_DISCH = 2'd3
  } rct_state_e;

  localparam int DISCH_MULT = 410;
endpackage

// File: rtl/rct_prescaler.sv
module rct_prescaler #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] div,
  output logic          tick
);
  logic [PW-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pcnt <= '0;
    else if (!en)         pcnt <= '0;
    else if (pcnt == div) pcnt <= '0;
    else                  pcnt <= pcnt + 1'b1;
  end

  assign tick = en && (pcnt == div);

  // R2: with a nonzero divider two ticks are never adjacent
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick);
endmodule

// File: rtl/rct_cmp_edge.sv
module rct_cmp_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_async,
  input  logic fall_sel,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cmp_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], cmp_async};
      prev_q <= cmp_s;
    end
  end

  assign cmp_s  = sync_q[SYNC_STAGES-1];
  assign edge_o = fall_sel ? (prev_q & ~cmp_s) : (cmp_s & ~prev_q);

  // R5: a detected crossing lasts a single cycle
  p_edge_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
endmodule

// File: rtl/rct_discharge.sv
module rct_discharge #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] div,
  output logic          active
);
  import rct_pkg::*;
  localparam int DW = PW + 9;

  logic [DW-1:0] dcnt;
  logic [DW-1:0] last;

  assign last = (DW'(div) + DW'(1)) * DW'(DISCH_MULT) - DW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      dcnt   <= '0;
    end else if (start) begin
      active <= 1'b1;
      dcnt   <= '0;
    end else if (active) begin
      if (dcnt == last) active <= 1'b0;
      else              dcnt   <= dcnt + 1'b1;
    end
  end

  // R6: a discharge run begins on the edge after its start
  p_dis_begin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active);
endmodule

// File: rtl/ramp_conv_timer.sv
module ramp_conv_timer #(
  parameter int CW = 16,
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] cfg_prescale,
  input  logic          cfg_count_down,
  input  logic          cfg_fall_edge,
  input  logic          cfg_ext_ramp,
  input  logic          conv_start,
  input  logic          ext_start,
  output logic          ext_ready,
  input  logic          cmp_in,
  output logic          cap_charge,
  output logic          cap_discharge,
  output logic [CW-1:0] res_data,
  output logic          res_valid,
  input  logic          res_ready,
  output logic          eoc_irq,
  output logic          wrap_flag,
  input  logic          wrap_clr
);
  import rct_pkg::*;

  rct_state_e    st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] r_div;
  logic          r_down, r_ext, r_pol;
  logic          tick, cmp_edge, at_term, fin, fin_wrap;

  rct_prescaler #(.PW(PW)) u_presc (
    .clk(clk), .rst_n(rst_n), .en(st == ST_COUNT), .div(r_div), .tick(tick)
  );

  rct_cmp_edge #(.SYNC_STAGES(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .cmp_async(cmp_in),
    .fall_sel(r_ext & r_pol), .edge_o(cmp_edge)
  );

  assign at_term  = r_down ? (cnt == '0) : (cnt == '1);
  assign fin_wrap = (st == ST_COUNT) && !cmp_edge && tick && at_term;
  assign fin      = (st == ST_COUNT) && (cmp_edge || (tick && at_term));

  rct_discharge #(.PW(PW)) u_dis (
    .clk(clk), .rst_n(rst_n), .start(fin && !r_ext), .div(r_div),
    .active(cap_discharge)
  );

  assign ext_ready  = (st == ST_ARM);
  assign cap_charge = (st == ST_COUNT) && !r_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      r_div  <= '0;
      r_down <= 1'b0;
      r_ext  <= 1'b0;
      r_pol  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (conv_start && !res_valid) begin
            r_div  <= cfg_prescale;
            r_down <= cfg_count_down;
            r_ext  <= cfg_ext_ramp;
            r_pol  <= cfg_fall_edge;
            cnt    <= cfg_count_down ? '1 : '0;
            st     <= cfg_ext_ramp ? ST_ARM : ST_COUNT;
          end
        end
        ST_ARM: begin
          if (ext_start) st <= ST_COUNT;
        end
        ST_COUNT: begin
          if (fin)       st  <= r_ext ? ST_IDLE : ST_DISCH;
          else if (tick) cnt <= r_down ? cnt - 1'b1 : cnt + 1'b1;
        end
        ST_DISCH: begin
          if (!cap_discharge) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_data  <= '0;
      res_valid <= 1'b0;
      eoc_irq   <= 1'b0;
      wrap_flag <= 1'b0;
    end else begin
      eoc_irq <= fin;
      if (fin) begin
        res_data  <= cnt;
        res_valid <= 1'b1;
      end else if (res_valid && res_ready) begin
        res_valid <= 1'b0;
      end
      if (fin_wrap)      wrap_flag <= 1'b1;
      else if (wrap_clr) wrap_flag <= 1'b0;
    end
  end

  // R3: a wrap always ends a conversion with an interrupt
  p_wrap_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrap_flag) |-> eoc_irq);
  // R4: on a wrap the result equals the terminal value of the direction
  p_wrap_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrap_flag) |-> (res_data == (r_down ? {CW{1'b0}} : {CW{1'b1}})));
  // R6: charge and discharge never overlap
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_discharge |-> !cap_charge);
  // R7: taking the external start drops the ready signal
  p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ready && ext_start) |=> !ext_ready);
  // R8: a pending result holds under back-pressure
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));
  // R9: the wrap flag stays set without a clear
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_flag && !wrap_clr) |=> wrap_flag);
  // R10: the interrupt is a single-cycle pulse
  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |=> !eoc_irq);
endmodule

// File: tb/sim_ramp_conv_timer.sv
module sim_ramp_conv_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_prescale = '0;
  logic        cfg_count_down = 1'b0, cfg_fall_edge = 1'b0, cfg_ext_ramp = 1'b0;
  logic        conv_start = 1'b0, ext_start = 1'b0, cmp_in = 1'b0;
  logic        res_ready = 1'b0, wrap_clr = 1'b0;
  logic        ext_ready, cap_charge, cap_discharge, res_valid, eoc_irq, wrap_flag;
  logic [15:0] res_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  ramp_conv_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_prescale(cfg_prescale),
    .cfg_count_down(cfg_count_down), .cfg_fall_edge(cfg_fall_edge),
    .cfg_ext_ramp(cfg_ext_ramp), .conv_start(conv_start), .ext_start(ext_start),
    .ext_ready(ext_ready), .cmp_in(cmp_in), .cap_charge(cap_charge),
    .cap_discharge(cap_discharge), .res_data(res_data), .res_valid(res_valid),
    .res_ready(res_ready), .eoc_irq(eoc_irq), .wrap_flag(wrap_flag),
    .wrap_clr(wrap_clr)
  );

  // {ext, down, fall, pad, P[12], W[16], expected[16]}
  localparam logic [47:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 12'd0, 16'd10, 16'd12},
    {1'b0, 1'b0, 1'b0, 1'b0, 12'd3, 16'd20, 16'd5},
    {1'b0, 1'b1, 1'b0, 1'b0, 12'd0, 16'd5,  16'hFFF8},
    {1'b1, 1'b0, 1'b0, 1'b0, 12'd0, 16'd30, 16'd32},
    {1'b1, 1'b1, 1'b1, 1'b0, 12'd1, 16'd40, 16'hFFEA},
    {1'b1, 1'b0, 1'b1, 1'b0, 12'd2, 16'd9,  16'd3},
    {1'b0, 1'b0, 1'b1, 1'b0, 12'd0, 16'd7,  16'd9},
    {1'b1, 1'b1, 1'b0, 1'b0, 12'd4, 16'd50, 16'hFFF5}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_valid(input int limit);
    for (int i = 0; i < limit && !res_valid; i++) @(negedge clk);
  endtask

  task automatic run_conv(input bit ext, input bit down, input bit fall,
                          input logic [11:0] p, input int w, input logic [15:0] exp);
    int dlen;
    cfg_ext_ramp = ext; cfg_count_down = down; cfg_fall_edge = fall;
    cfg_prescale = p;
    cmp_in = ext & fall;
    repeat (5) @(negedge clk);
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    if (ext) begin
      check("R7 ready raised when armed", ext_ready, 1);
      ext_start = 1'b1;
      @(negedge clk);
      ext_start = 1'b0;
      check("R7 ready dropped after start", ext_ready, 0);
    end else begin
      check("R6 charge on while counting", cap_charge, 1);
    end
    repeat (w) @(negedge clk);
    cmp_in = ~cmp_in;
    wait_valid(300);
    check("R2/R4/R5 captured count", res_data, exp);
    check("R10 irq with valid", eoc_irq, 1);
    res_ready = 1'b1;
    dlen = (!ext && cap_discharge) ? 1 : 0;
    @(negedge clk);
    res_ready = 1'b0;
    check("R8 valid cleared by ready", res_valid, 0);
    check("R10 irq one cycle", eoc_irq, 0);
    if (!ext) begin
      while (cap_discharge) begin
        dlen++;
        @(negedge clk);
      end
      check("R6 discharge length", dlen, (int'(p) + 1) * 410);
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected<190000 cycles", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 res_valid", res_valid, 0);
    check("R1 res_data", res_data, 0);
    check("R1 wrap_flag", wrap_flag, 0);
    check("R1 eoc_irq", eoc_irq, 0);
    check("R1 ext_ready", ext_ready, 0);
    check("R1 cap_charge", cap_charge, 0);
    check("R1 cap_discharge", cap_discharge, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 8; k++) begin
      run_conv(VEC[k][47], VEC[k][46], VEC[k][45], VEC[k][43:32],
               int'(VEC[k][31:16]), VEC[k][15:0]);
    end

    // R8: back-pressure holds the result and blocks new starts
    run_hold();

    // R6: a start request during discharge has no effect
    cfg_ext_ramp = 1'b0; cfg_count_down = 1'b0; cfg_prescale = 12'd0;
    cmp_in = 1'b0;
    repeat (5) @(negedge clk);
    conv_start = 1'b1; @(negedge clk); conv_start = 1'b0;
    repeat (4) @(negedge clk);
    cmp_in = 1'b1;
    wait_valid(300);
    res_ready = 1'b1; @(negedge clk); res_ready = 1'b0;
    cfg_ext_ramp = 1'b1;
    conv_start = 1'b1; @(negedge clk); conv_start = 1'b0;
    while (cap_discharge) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R6 start during discharge ignored (ready)", ext_ready, 0);
    check("R6 start during discharge ignored (charge)", cap_charge, 0);
    check("R6 start during discharge ignored (valid)", res_valid, 0);

    // R3: up-count overflow
    cfg_ext_ramp = 1'b1; cfg_count_down = 1'b0; cfg_fall_edge = 1'b0;
    cmp_in = 1'b0;
    repeat (5) @(negedge clk);
    conv_start = 1'b1; @(negedge clk); conv_start = 1'b0;
    ext_start = 1'b1; @(negedge clk); ext_start = 1'b0;
    wait_valid(70000);
    check("R3 overflow result", res_data, 16'hFFFF);
    check("R3 overflow flag", wrap_flag, 1);
    check("R3 overflow irq", eoc_irq, 1);
    res_ready = 1'b1; @(negedge clk); res_ready = 1'b0;

    // R9: flag survives a normal conversion, then clears
    run_conv(1'b1, 1'b0, 1'b0, 12'd0, 6, 16'd8);
    check("R9 flag sticky", wrap_flag, 1);
    wrap_clr = 1'b1; @(negedge clk); wrap_clr = 1'b0;
    check("R9 flag cleared", wrap_flag, 0);

    // R4: down-count underflow
    cfg_count_down = 1'b1;
    conv_start = 1'b1; @(negedge clk); conv_start = 1'b0;
    ext_start = 1'b1; @(negedge clk); ext_start = 1'b0;
    wait_valid(70000);
    check("R4 underflow result", res_data, 16'h0000);
    check("R4 underflow flag", wrap_flag, 1);
    res_ready = 1'b1; @(negedge clk); res_ready = 1'b0;

    repeat (3) @(negedge clk);
    finish_run();
  end

  task automatic run_hold();
    cfg_ext_ramp = 1'b1; cfg_count_down = 1'b0; cfg_fall_edge = 1'b0;
    cfg_prescale = 12'd0; cmp_in = 1'b0;
    repeat (5) @(negedge clk);
    conv_start = 1'b1; @(negedge clk); conv_start = 1'b0;
    ext_start = 1'b1; @(negedge clk); ext_start = 1'b0;
    repeat (3) @(negedge clk);
    cmp_in = 1'b1;
    wait_valid(300);
    check("R8 held result", res_data, 16'd5);
    conv_start = 1'b1; @(negedge clk); conv_start = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R8 start ignored while pending", ext_ready, 0);
      check("R8 result stable", res_data, 16'd5);
      check("R8 valid held", res_valid, 1);
    end
    res_ready = 1'b1; @(negedge clk); res_ready = 1'b0;
    check("R8 valid released", res_valid, 0);
  endtask
endmodule